// File: doc/BRIEF.md
# Conditional Write Strobe Dispatcher

This block produces the single write pulse that commits a command's result at execute time. A one-hot decoder indexed by the opcode selects one of sixteen destinations, such as scratch RAM, the program counter, display memory or the boolean flag. The pulse is allowed only in the commit phase of a four-phase step sequence, and only while the core is in its execute step.

A command can carry a conditional bit. When that bit is set, the command commits only if the stored boolean flag is 1. The flag is a one-bit register. Three opcodes reload it from the less, equal or greater output of an external magnitude comparator. Every other opcode leaves it unchanged. The datapath multiplexers and the ALU sit outside this block. Their comparator results and the phase count arrive as inputs.

Top module: `strobe_dispatch`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, all sixteen strobes are 0 and `bool_flag` is 0.
- R2: A commit request is `exec_step`=1 with `phase`=2 (phases are numbered 0 to 3; the third phase has code 2). When a commit request arrives with `cond_bit`=0, the next cycle shows `wr_strobe` equal to 1 shifted left by the sampled opcode, for one cycle.
- R3: In any cycle where `exec_step` is 0 or `phase` is not 2, every strobe in the next cycle is 0.
- R4: A commit request with `cond_bit`=1 while `bool_flag` is 0 gives all-zero strobes in the next cycle and leaves `bool_flag` unchanged.
- R5: A commit request with `cond_bit`=1 while `bool_flag` is 1 fires the decoded strobe exactly as in R2.
- R6: With `cond_bit`=0 the strobe fires whether `bool_flag` is 0 or 1.
- R7: A commit that is not suppressed and carries opcode 13, 14 or 15 loads `bool_flag` from `cmp_lt`, `cmp_eq` or `cmp_gt` respectively. The new value is visible in the next cycle, together with the strobe.
- R8: `bool_flag` holds its value in every cycle that is not a commit of opcode 13, 14 or 15, and it also holds through a suppressed commit.
- R9: At most one bit of `wr_strobe` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_step | input | 1 | High during the command's execute step |
| phase | input | 2 | Current phase of the four-phase step, 0 to 3 |
| opcode | input | 4 | Opcode of the command being executed |
| cond_bit | input | 1 | Conditional prefix bit of the command |
| cmp_lt | input | 1 | Comparator result: A less than B |
| cmp_eq | input | 1 | Comparator result: A equal to B |
| cmp_gt | input | 1 | Comparator result: A greater than B |
| wr_strobe | output | 16 | One-hot destination write strobes |
| bool_flag | output | 1 | Stored boolean flag |

## Verification
Both results are registered. The strobe and the flag update that a commit request causes appear exactly one clock edge after the cycle in which the request is presented, and they last one cycle. The bench drives each stimulus on the falling edge and samples both outputs just after the following rising edge. The expected strobe is judged against the flag value from before that edge, since the flag moves on the same edge. The sweep covers every opcode, conditional bit, phase code and execute level, first with the flag cleared and then with it set.

// File: rtl/sd_pkg.sv
package sd_pkg;
  localparam int unsigned PHASE_COUNT = 4;
  localparam int unsigned PHASE_W     = $clog2(PHASE_COUNT);

  typedef enum logic [1:0] {
    REL_NONE = 2'd0,
    REL_LT   = 2'd1,
    REL_EQ   = 2'd2,
    REL_GT   = 2'd3
  } rel_sel_e;
endpackage

// File: rtl/sd_commit_gate.sv
module sd_commit_gate #(
  parameter int unsigned PHASE_W      = 2,
  parameter int unsigned COMMIT_PHASE = 2
) (
  input  logic               exec_step,
  input  logic [PHASE_W-1:0] phase,
  input  logic               cond_bit,
  input  logic               flag_q,
  output logic               commit_req,
  output logic               commit_ok
);
  always_comb begin
    commit_req = exec_step && (phase == PHASE_W'(COMMIT_PHASE));
    // Conditional commands need a set flag; plain ones always pass
    commit_ok  = commit_req && (!cond_bit || flag_q);
  end
endmodule

// File: rtl/sd_onehot_dec.sv
module sd_onehot_dec #(
  parameter int unsigned SEL_W = 4,
  localparam int unsigned N_OUT = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [N_OUT-1:0] dec
);
  for (genvar gi = 0; gi < N_OUT; gi++) begin : g_line
    assign dec[gi] = en && (sel == SEL_W'(gi));
  end
endmodule

// File: rtl/sd_flag_reg.sv
module sd_flag_reg
  import sd_pkg::*;
#(
  parameter int unsigned OP_W  = 4,
  parameter int unsigned OP_LT = 13,
  parameter int unsigned OP_EQ = 14,
  parameter int unsigned OP_GT = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            commit_ok,
  input  logic [OP_W-1:0] opcode,
  input  logic            cmp_lt,
  input  logic            cmp_eq,
  input  logic            cmp_gt,
  output logic            flag_q
);
  rel_sel_e rel_sel;
  logic     flag_load;
  logic     flag_d;

  always_comb begin
    if (opcode == OP_W'(OP_LT))      rel_sel = REL_LT;
    else if (opcode == OP_W'(OP_EQ)) rel_sel = REL_EQ;
    else if (opcode == OP_W'(OP_GT)) rel_sel = REL_GT;
    else                             rel_sel = REL_NONE;

    flag_load = commit_ok && (rel_sel != REL_NONE);

    unique case (rel_sel)
      REL_LT:  flag_d = cmp_lt;
      REL_EQ:  flag_d = cmp_eq;
      REL_GT:  flag_d = cmp_gt;
      default: flag_d = flag_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (flag_load) flag_q <= flag_d;
  end
endmodule

// File: rtl/strobe_dispatch.sv
module strobe_dispatch
  import sd_pkg::*;
#(
  parameter int unsigned OP_W         = 4,
  parameter int unsigned COMMIT_PHASE = 2,
  parameter int unsigned OP_LT        = 13,
  parameter int unsigned OP_EQ        = 14,
  parameter int unsigned OP_GT        = 15,
  localparam int unsigned N_DEST      = 1 << OP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_step,
  input  logic [PHASE_W-1:0] phase,
  input  logic [OP_W-1:0]    opcode,
  input  logic               cond_bit,
  input  logic               cmp_lt,
  input  logic               cmp_eq,
  input  logic               cmp_gt,
  output logic [N_DEST-1:0]  wr_strobe,
  output logic               bool_flag
);
  logic              commit_req;
  logic              commit_ok;
  logic [N_DEST-1:0] strobe_d;
  logic [N_DEST-1:0] strobe_q;

  sd_commit_gate #(
    .PHASE_W     (PHASE_W),
    .COMMIT_PHASE(COMMIT_PHASE)
  ) u_gate (
    .exec_step (exec_step),
    .phase     (phase),
    .cond_bit  (cond_bit),
    .flag_q    (bool_flag),
    .commit_req(commit_req),
    .commit_ok (commit_ok)
  );

  sd_onehot_dec #(
    .SEL_W(OP_W)
  ) u_dec (
    .en (commit_ok),
    .sel(opcode),
    .dec(strobe_d)
  );

  sd_flag_reg #(
    .OP_W (OP_W),
    .OP_LT(OP_LT),
    .OP_EQ(OP_EQ),
    .OP_GT(OP_GT)
  ) u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit_ok(commit_ok),
    .opcode   (opcode),
    .cmp_lt   (cmp_lt),
    .cmp_eq   (cmp_eq),
    .cmp_gt   (cmp_gt),
    .flag_q   (bool_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= '0;
    else        strobe_q <= strobe_d;
  end

  assign wr_strobe = strobe_q;
endmodule

// File: rtl/strobe_dispatch_chk.sv
module strobe_dispatch_chk #(
  parameter int unsigned OP_W         = 4,
  parameter int unsigned PHASE_W      = 2,
  parameter int unsigned COMMIT_PHASE = 2,
  parameter int unsigned OP_EQ        = 14,
  localparam int unsigned N_DEST      = 1 << OP_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               exec_step,
  input logic [PHASE_W-1:0] phase,
  input logic [OP_W-1:0]    opcode,
  input logic               cond_bit,
  input logic               cmp_eq,
  input logic [N_DEST-1:0]  wr_strobe,
  input logic               bool_flag
);
  logic req;
  assign req = exec_step && (phase == PHASE_W'(COMMIT_PHASE));

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (wr_strobe == '0)); // R3
  AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strobe)); // R9
  AST_PLAIN_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !cond_bit) |=> (wr_strobe == (N_DEST'(1) << $past(opcode)))); // R2
  AST_COND_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cond_bit && !bool_flag) |=> ((wr_strobe == '0) && !bool_flag)); // R4
  AST_COND_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cond_bit && bool_flag) |=> (wr_strobe == (N_DEST'(1) << $past(opcode)))); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(bool_flag)); // R8
  AST_FLAG_EQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && (!cond_bit || bool_flag) && (opcode == OP_W'(OP_EQ)))
      |=> (bool_flag == $past(cmp_eq))); // R7
endmodule

bind strobe_dispatch strobe_dispatch_chk #(
  .OP_W        (OP_W),
  .PHASE_W     (sd_pkg::PHASE_W),
  .COMMIT_PHASE(COMMIT_PHASE),
  .OP_EQ       (OP_EQ)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .exec_step(exec_step),
  .phase    (phase),
  .opcode   (opcode),
  .cond_bit (cond_bit),
  .cmp_eq   (cmp_eq),
  .wr_strobe(wr_strobe),
  .bool_flag(bool_flag)
);

// File: tb/strobe_dispatch_bench.sv
`timescale 1ns/1ps
module strobe_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_step;
  logic [1:0]  phase;
  logic [3:0]  opcode;
  logic        cond_bit;
  logic        cmp_lt, cmp_eq, cmp_gt;
  logic [15:0] wr_strobe;
  logic        bool_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit model_flag;

  always #2.5 clk = ~clk;

  strobe_dispatch u_strobe_dispatch (
    .clk(clk), .rst_n(rst_n), .exec_step(exec_step), .phase(phase),
    .opcode(opcode), .cond_bit(cond_bit), .cmp_lt(cmp_lt), .cmp_eq(cmp_eq),
    .cmp_gt(cmp_gt), .wr_strobe(wr_strobe), .bool_flag(bool_flag)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One stimulus cycle: drive at falling edge, sample after the next rising edge
  task automatic step(bit ex, bit [1:0] ph, bit [3:0] op, bit cb,
                      bit lt, bit eq, bit gt);
    bit          commit;
    bit [15:0]   exp_wr;
    bit          exp_flag;
    string       tag;
    @(negedge clk);
    exec_step = ex; phase = ph; opcode = op; cond_bit = cb;
    cmp_lt = lt; cmp_eq = eq; cmp_gt = gt;
    commit   = ex && (ph == 2'd2) && (!cb || model_flag);
    exp_wr   = commit ? (16'h1 << op) : 16'h0;
    exp_flag = model_flag;
    if (commit && op == 4'd13) exp_flag = lt;
    if (commit && op == 4'd14) exp_flag = eq;
    if (commit && op == 4'd15) exp_flag = gt;
    if (!(ex && ph == 2'd2))  tag = "R3";
    else if (cb && !model_flag) tag = "R4";
    else if (cb)              tag = "R5";
    else if (model_flag)      tag = "R6";
    else                      tag = "R2";
    @(posedge clk);
    #1;
    check(tag, wr_strobe, exp_wr);
    check((commit && op >= 4'd13) ? "R7" : "R8", {15'b0, bool_flag}, {15'b0, exp_flag});
    check("R9", {15'b0, ($countones(wr_strobe) <= 1)}, 16'h1);
    model_flag = exp_flag;
  endtask

  initial begin
    rst_n = 1'b0;
    exec_step = 0; phase = 0; opcode = 0; cond_bit = 0;
    cmp_lt = 0; cmp_eq = 0; cmp_gt = 0;
    model_flag = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", wr_strobe, 16'h0);
    check("R1", {15'b0, bool_flag}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1", wr_strobe, 16'h0);
    check("R1", {15'b0, bool_flag}, 16'h0);

    for (int f = 0; f < 2; f++) begin
      for (int op = 0; op < 16; op++) begin
        for (int cb = 0; cb < 2; cb++) begin
          for (int ph = 0; ph < 4; ph++) begin
            for (int ex = 0; ex < 2; ex++) begin
              // restore the flag level for this pass (plain commit of opcode 14)
              step(1'b1, 2'd2, 4'd14, 1'b0, 1'b0, f[0], 1'b0);
              step(ex[0], ph[1:0], op[3:0], cb[0],
                   op[0], ~f[0], op[1] ^ ph[0]);
            end
          end
        end
      end
    end

    // flag relation selection: each relation opcode under each comparator value
    for (int r = 13; r < 16; r++) begin
      for (int v = 0; v < 2; v++) begin
        step(1'b1, 2'd2, r[3:0], 1'b0, v[0], v[0], v[0]);   // R7
        step(1'b1, 2'd2, r[3:0], 1'b0, ~v[0], ~v[0], ~v[0]); // R7
        step(1'b0, 2'd0, 4'd0, 1'b0, v[0], v[0], v[0]);      // R8 idle
      end
    end
    // only the selected relation counts
    step(1'b1, 2'd2, 4'd13, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 2'd2, 4'd14, 1'b0, 1'b1, 1'b0, 1'b1);
    step(1'b1, 2'd2, 4'd15, 1'b0, 1'b0, 1'b1, 1'b1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog actual=running expected=finished");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule